// File: doc/BRIEF.md
# Receive Character Queue with Error Flags

This block buffers characters coming from a serial receiver until software reads them. Each stored entry holds the data byte and three error flags: break, framing error and parity error. The flags stay attached to their byte as it moves toward the head of the queue. The receiver writes one character per cycle, together with its length code and flags. Software pops one byte per read. A separate status view shows error information for the character at the head of the queue, so status can be sampled before the byte it describes is removed.

Two reporting modes are available. In per-character mode, the status view shows the flags of the current head entry. In accumulated mode, it shows the OR of the flags of every character accepted since the last clear-errors command. A clear-errors command is the code 0x04 written on the command strobe, and it also clears a sticky overrun flag. Empty, full and occupancy outputs, plus a service-request line, let the surrounding logic schedule reads.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `count`=0, `rx_service`=0, `overrun`=0, `status`=0 and `rd_data`=0.
- R2: Characters are read out in the order they were written. The queue holds 16 entries, and `full` is 1 exactly when `count` is 16.
- R3: A write while `full` is 1 is dropped: the contents and `count` do not change. It also sets `overrun`, which stays at 1 until cleared.
- R4: The length code `wr_len` gives the character size: 0=5 bits, 1=6 bits, 2=7 bits, 3=8 bits. Data bits above that size are stored and read back as 0.
- R5: With `blk_mode`=0, `status` is {break, framing, parity} of the head entry, in bits [2],[1],[0]. It changes to the next entry's flags on the cycle after a pop. It is 0 when the queue is empty.
- R6: With `blk_mode`=1, `status` is the OR of the flags of all characters accepted since the last clear-errors command, and it does not change on a pop. A command code of 0x04 clears it. Any other command code leaves it unchanged.
- R7: A command of code 0x04 clears `overrun`. Any other code leaves it set.
- R8: A read while the queue is empty gives `rd_data`=0 and leaves `count` and the contents unchanged.
- R9: A write and a read in the same cycle on a queue that is neither empty nor full leave `count` unchanged, and both operations take effect.
- R10: `rx_service` is 1 exactly when the queue holds at least one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Received character, right aligned |
| wr_len | input | 2 | Character length code (0=5 .. 3=8 bits) |
| wr_brk | input | 1 | Break flag of this character |
| wr_fe | input | 1 | Framing-error flag of this character |
| wr_pe | input | 1 | Parity-error flag of this character |
| rd_en | input | 1 | Pop the head character |
| rd_data | output | 8 | Head character data, 0 when empty |
| blk_mode | input | 1 | 0 = per-character status, 1 = accumulated status |
| status | output | 3 | {break, framing, parity} status view |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code; 0x04 clears errors |
| overrun | output | 1 | Sticky dropped-write flag |
| empty | output | 1 | Queue holds no characters |
| full | output | 1 | Queue holds 16 characters |
| count | output | 5 | Number of stored characters |
| rx_service | output | 1 | Service request, queue not empty |

## Verification
A read pointer that drifts, or a count that does not match the pointers, shows up at the first pop after it happens. `rd_data` returns a byte out of order, and `empty` or `full` flips on the wrong write. Flags that are stored in the wrong entry appear in `status` one cycle after the pop that exposes that entry. An accumulator or overrun flag that fails to hold, or that clears on the wrong code, is visible at the ports on the cycle after the command.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rsf_entry_t;

  localparam logic [7:0] CMD_CLR_ERR = 8'h04;
endpackage

// File: rtl/rsf_rst_sync.sv
module rsf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/rsf_store.sv
module rsf_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_req,
  input  logic                pop_req,
  input  rsf_pkg::rsf_entry_t wdat,
  output rsf_pkg::rsf_entry_t head,
  output logic                push_ok,
  output logic                pop_ok,
  output logic                empty,
  output logic                full,
  output logic [CW-1:0]       count
);
  rsf_pkg::rsf_entry_t mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_n;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign head    = mem_q[rp_q];

  always_comb begin
    wp_n  = push_ok ? wp_q + AW'(1) : wp_q;
    rp_n  = pop_ok  ? rp_q + AW'(1) : rp_q;
    cnt_n = count;
    if (push_ok && !pop_ok) cnt_n = count + CW'(1);
    if (pop_ok && !push_ok) cnt_n = count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      count <= cnt_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = push_ok && (wp_q == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (slot_en) mem_q[i] <= wdat;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_req && !pop_req |=> full && $stable(wp_q));
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop_req && !push_req |=> empty && $stable(rp_q));
  p_pushpop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && pop_req && !empty && !full |=> $stable(count));
endmodule

// File: rtl/rsf_err_track.sv
module rsf_err_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push_ok,
  input  logic       drop,
  input  logic [2:0] new_flags,
  output logic [2:0] acc,
  output logic       ovr
);
  logic [2:0] acc_n;
  logic       ovr_n;

  always_comb begin
    acc_n = clr ? 3'b000 : acc;
    if (push_ok) acc_n = acc_n | new_flags;
    ovr_n = (clr ? 1'b0 : ovr) | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ovr <= 1'b0;
    end else begin
      acc <= acc_n;
      ovr <= ovr_n;
    end
  end

  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !clr |=> ovr);
  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !drop |=> !ovr);
  p_acc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !push_ok |=> acc == 3'b000);
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !push_ok |=> $stable(acc));
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [1:0]    wr_len,
  input  logic          wr_brk,
  input  logic          wr_fe,
  input  logic          wr_pe,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          blk_mode,
  output logic [2:0]    status,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_code,
  output logic          overrun,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count,
  output logic          rx_service
);
  import rsf_pkg::*;

  logic       rst_n_s;
  rsf_entry_t wdat, head;
  logic       push_ok, pop_ok, clr;
  logic [7:0] len_mask;
  logic [2:0] acc;

  rsf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign len_mask  = 8'hFF >> (2'd3 - wr_len);
  assign wdat.brk  = wr_brk;
  assign wdat.fe   = wr_fe;
  assign wdat.pe   = wr_pe;
  assign wdat.data = wr_data & len_mask;
  assign clr       = cmd_wr && (cmd_code == CMD_CLR_ERR);

  rsf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n_s), .push_req(wr_en), .pop_req(rd_en),
    .wdat(wdat), .head(head), .push_ok(push_ok), .pop_ok(pop_ok),
    .empty(empty), .full(full), .count(count)
  );

  rsf_err_track u_err (
    .clk(clk), .rst_n(rst_n_s), .clr(clr), .push_ok(push_ok),
    .drop(wr_en && full), .new_flags({wr_brk, wr_fe, wr_pe}),
    .acc(acc), .ovr(overrun)
  );

  assign rx_service = !empty;
  assign rd_data    = empty ? 8'h00 : head.data;
  assign status     = blk_mode ? acc
                    : (empty ? 3'b000 : {head.brk, head.fe, head.pe});

  p_service_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_service |-> count != '0);
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    empty |-> rd_data == 8'h00);
endmodule

// File: tb/rx_status_fifo_test.sv
module rx_status_fifo_test;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, rd_en, wr_brk, wr_fe, wr_pe, blk_mode, cmd_wr;
  logic [7:0] wr_data, cmd_code, rd_data;
  logic [1:0] wr_len;
  logic [2:0] status;
  logic overrun, empty, full, rx_service;
  logic [4:0] count;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_status_fifo uut (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; cmd_wr = 0;
  endtask

  task automatic push(logic [7:0] d, logic [1:0] len, logic [2:0] f);
    wr_en = 1; wr_data = d; wr_len = len; {wr_brk, wr_fe, wr_pe} = f;
    @(posedge clk); #1 idle();
  endtask

  task automatic pop();
    rd_en = 1; @(posedge clk); #1 idle();
  endtask

  task automatic command(logic [7:0] c);
    cmd_wr = 1; cmd_code = c; @(posedge clk); #1 idle();
  endtask

  task automatic t_reset();
    check("R1 empty", empty, 1); check("R1 full", full, 0);
    check("R1 count", count, 0); check("R1 service", rx_service, 0);
    check("R1 overrun", overrun, 0); check("R1 status", status, 0);
    check("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_fill_order();
    for (int i = 0; i < 16; i++) push(8'(i * 13 + 1), 2'd3, 3'b000);
    check("R2 full", full, 1); check("R2 count", count, 16);
    check("R10 service", rx_service, 1);
    push(8'hEE, 2'd3, 3'b000);
    check("R3 count after drop", count, 16); check("R3 overrun", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      check("R2 order", rd_data, (i * 13 + 1) & 8'hFF);
      pop();
    end
    check("R3 dropped byte absent", empty, 1);
    check("R10 service idle", rx_service, 0);
    check("R3 overrun sticky", overrun, 1);
  endtask

  task automatic t_overrun_clear();
    command(8'h05); check("R7 other code", overrun, 1);
    command(8'h04); check("R7 clear", overrun, 0);
  endtask

  task automatic t_mask();
    for (int l = 0; l < 4; l++) push(8'hFF, 2'(l), 3'b000);
    check("R4 len5", rd_data, 8'h1F); pop();
    check("R4 len6", rd_data, 8'h3F); pop();
    check("R4 len7", rd_data, 8'h7F); pop();
    check("R4 len8", rd_data, 8'hFF); pop();
  endtask

  task automatic t_char_status();
    blk_mode = 0;
    push(8'hA1, 2'd3, 3'b100); push(8'hB2, 2'd3, 3'b010); push(8'hC3, 2'd3, 3'b001);
    check("R5 head brk", status, 3'b100); check("R5 data A", rd_data, 8'hA1); pop();
    check("R5 head fe", status, 3'b010); check("R5 data B", rd_data, 8'hB2); pop();
    check("R5 head pe", status, 3'b001); pop();
    check("R5 empty status", status, 0);
  endtask

  task automatic t_block_status();
    blk_mode = 1;
    command(8'h04);
    push(8'h11, 2'd3, 3'b001); push(8'h22, 2'd3, 3'b010); push(8'h33, 2'd3, 3'b000);
    check("R6 accumulated", status, 3'b011);
    pop(); pop(); pop();
    check("R6 kept after pops", status, 3'b011);
    command(8'h02); check("R6 other code", status, 3'b011);
    command(8'h04); check("R6 cleared", status, 0);
    blk_mode = 0;
  endtask

  task automatic t_empty_read();
    check("R8 data", rd_data, 0);
    pop();
    check("R8 count", count, 0); check("R8 empty", empty, 1);
    push(8'h5A, 2'd3, 3'b000);
    check("R8 pointer intact", rd_data, 8'h5A); pop();
  endtask

  task automatic t_push_pop();
    push(8'h01, 2'd3, 3'b000); push(8'h02, 2'd3, 3'b000);
    wr_en = 1; wr_data = 8'h03; wr_len = 2'd3; {wr_brk, wr_fe, wr_pe} = 3'b000;
    rd_en = 1; @(posedge clk); #1 idle();
    check("R9 count", count, 2);
    check("R9 next", rd_data, 8'h02); pop();
    check("R9 new", rd_data, 8'h03); pop();
    check("R9 empty", empty, 1);
  endtask

  initial begin
    idle(); wr_data = 0; wr_len = 0; {wr_brk, wr_fe, wr_pe} = 0;
    blk_mode = 0; cmd_code = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    t_reset(); t_fill_order(); t_overrun_clear(); t_mask();
    t_char_status(); t_block_status(); t_empty_read(); t_push_pop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule